// File: doc/BRIEF.md
# Constant Twiddle Rotator for the Final Transform Stage

This block multiplies one complex sample per clock by one of four fixed twiddle constants and uses no general multiplier. It sits between the sixth butterfly and the last butterfly of a 128-point streaming transform pipeline. A 2-bit select taken from the frame counter picks the factor for each sample: unity, −j, the −45° rotation (1 − j)/√2, or the −135° rotation (−1 − j)/√2.

Unity and −j cost no arithmetic beyond wiring and a negation. The two diagonal factors have real and imaginary parts of equal magnitude. For these, the block first forms the sum and the difference of the two input components with two adder/subtractors. It then scales each of them by 1/√2 through a fixed signed-digit shift-and-add tree. Every factor takes the same two-clock latency, so a valid flag travels in step with the data. Results are rounded and clipped back to the 13-bit sample width.

Top module: `twiddle_csd_mul`

## Requirements
- R1: While `rst` is high, on the next clock edge `out_valid`, `out_re` and `out_im` all become 0, whatever the inputs are.
- R2: `out_valid` equals the value `in_valid` had two clock edges earlier, for every select value.
- R3: Select code 2'b00 (unity) returns the accepted sample unchanged on both components.
- R4: Select code 2'b01 (−j) returns real = input imaginary and imaginary = −(input real). Negating −4096 clips to +4095.
- R5: Select code 2'b10 (−45°) returns real = S(re + im) and imaginary = S(im − re). S(x) = clip(floor((x·181 + 128) / 256)). The factor 181/256 comes from the signed digits 2^-1 + 2^-3 + 2^-4 + 2^-6 + 2^-8.
- R6: Select code 2'b11 (−135°) returns real = S(im − re) and imaginary = S(−(re + im)), with S as in R5.
- R7: Any result outside [−4096, 4095] is clipped to the nearest bound. For example, re = im = 4095 under code 2'b10 gives real = 4095.
- R8: When a cycle carries `in_valid` low, that cycle does not change `out_re` and `out_im`. They keep the last accepted result.
- R9: Samples can arrive on consecutive clocks, each with a different select value, and each is processed with its own select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample qualifier |
| in_sel | input | 2 | Twiddle select: 00 unity, 01 −j, 10 −45°, 11 −135° |
| in_re | input | 13 | Input real part, two's complement |
| in_im | input | 13 | Input imaginary part, two's complement |
| out_valid | output | 1 | Result qualifier, two clocks after `in_valid` |
| out_re | output | 13 | Rotated real part, rounded and clipped |
| out_im | output | 13 | Rotated imaginary part, rounded and clipped |

## Verification
The embedded properties assume that `in_sel`, `in_re` and `in_im` are known values whenever `in_valid` is high. They also assume that reset is applied for at least one clock before data flows. The sign-preservation property further relies on the scaled operand carrying its sign into the rounded product. This holds only because the rounding constant is smaller than one scaled unit.

The bench drives every input only on the falling edge and holds it for a full period, so the data and the select always settle before the rising edge. It keeps the operands inside the 13-bit two's complement range and reaches the clipping bounds only through the extreme codes −4096 and +4095.

// File: rtl/twm_pkg.sv
package twm_pkg;

    // Twiddle select encoding (frame-counter driven)
    typedef enum logic [1:0] {
        TW_ONE      = 2'b00,
        TW_NEG_J    = 2'b01,
        TW_ROT_M45  = 2'b10,
        TW_ROT_M135 = 2'b11
    } tw_sel_e;

    // Signed-digit approximation of 1/sqrt(2): sum of 2^-SHIFT terms
    localparam int CSD_TERMS = 5;
    localparam int CSD_FRAC  = 8;
    localparam logic [CSD_TERMS*4-1:0] CSD_SHIFTS = {4'd8, 4'd6, 4'd4, 4'd3, 4'd1};
    localparam logic [CSD_TERMS-1:0]   CSD_NEGS   = '0;

    // Control travelling alongside the data
    typedef struct packed {
        logic vld;
        logic scale;
    } tw_ctl_t;

endpackage

// File: rtl/twm_prep.sv
module twm_prep
    import twm_pkg::*;
#(
    parameter int DW = 13,
    localparam int OW = DW + 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [1:0]           in_sel,
    input  logic signed [DW-1:0] in_re,
    input  logic signed [DW-1:0] in_im,
    output tw_ctl_t              ctl_q,
    output logic signed [OW-1:0] op_re_q,
    output logic signed [OW-1:0] op_im_q
);

    logic signed [OW-1:0] a_ext, b_ext, sum_ab, dif_ba;
    logic signed [OW-1:0] nxt_re, nxt_im;
    logic                 nxt_scale;
    tw_sel_e              sel_e;

    assign sel_e  = tw_sel_e'(in_sel);
    assign a_ext  = OW'(in_re);
    assign b_ext  = OW'(in_im);
    assign sum_ab = a_ext + b_ext;
    assign dif_ba = b_ext - a_ext;

    always_comb begin
        nxt_re    = a_ext;
        nxt_im    = b_ext;
        nxt_scale = 1'b0;
        unique case (sel_e)
            TW_ONE: begin
                nxt_re = a_ext;
                nxt_im = b_ext;
            end
            TW_NEG_J: begin
                nxt_re = b_ext;
                nxt_im = -a_ext;
            end
            TW_ROT_M45: begin
                nxt_re    = sum_ab;
                nxt_im    = dif_ba;
                nxt_scale = 1'b1;
            end
            TW_ROT_M135: begin
                nxt_re    = dif_ba;
                nxt_im    = -sum_ab;
                nxt_scale = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= '0;
            op_re_q <= '0;
            op_im_q <= '0;
        end else begin
            ctl_q.vld <= in_valid;
            if (in_valid) begin
                ctl_q.scale <= nxt_scale;
                op_re_q     <= nxt_re;
                op_im_q     <= nxt_im;
            end
        end
    end

    // R3: unity factor forwards both components unchanged
    p_unity_pass_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && $past(in_sel) == 2'b00)
        |-> (op_re_q == OW'($past(in_re)) && op_im_q == OW'($past(in_im)) && !ctl_q.scale));

    // R4: -j swaps components and negates the new imaginary part
    p_negj_swap_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && $past(in_sel) == 2'b01)
        |-> (op_re_q == OW'($past(in_im)) && op_im_q == -OW'($past(in_re))));

    // R5/R6: diagonal factors take the scaling path, trivial ones bypass it
    p_scale_path_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid)) |-> (ctl_q.scale == $past(in_sel[1])));

endmodule

// File: rtl/twm_csd_scale.sv
module twm_csd_scale #(
    parameter int                IW     = 15,
    parameter int                FRAC   = 8,
    parameter int                NT     = 5,
    parameter logic [NT*4-1:0]   SHIFTS = {4'd8, 4'd6, 4'd4, 4'd3, 4'd1},
    parameter logic [NT-1:0]     NEGS   = '0,
    localparam int               AW     = IW + FRAC + 2
) (
    input  logic signed [IW-1:0] x,
    output logic signed [IW-1:0] y
);

    logic signed [AW-1:0] x_ext;
    logic signed [AW-1:0] term [NT];
    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] rnd;

    assign x_ext = AW'(x);

    for (genvar i = 0; i < NT; i++) begin : g_term
        localparam int SH = int'(SHIFTS[i*4 +: 4]);
        assign term[i] = x_ext <<< (FRAC - SH);
    end

    always_comb begin
        acc = '0;
        for (int i = 0; i < NT; i++) begin
            if (NEGS[i]) acc = acc - term[i];
            else         acc = acc + term[i];
        end
        rnd = acc + AW'(1 << (FRAC - 1));
    end

    assign y = IW'(rnd >>> FRAC);

endmodule

// File: rtl/twm_sat.sv
module twm_sat #(
    parameter int IW = 15,
    parameter int OW = 13
) (
    input  logic signed [IW-1:0] d,
    output logic signed [OW-1:0] q
);

    localparam int MAXV = 2 ** (OW - 1) - 1;
    localparam int MINV = -(2 ** (OW - 1));

    always_comb begin
        if (d > IW'(MAXV))      q = OW'(MAXV);
        else if (d < IW'(MINV)) q = OW'(MINV);
        else                    q = d[OW-1:0];
    end

endmodule

// File: rtl/twiddle_csd_mul.sv
module twiddle_csd_mul
    import twm_pkg::*;
#(
    parameter int DW = 13,
    localparam int OW = DW + 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [1:0]           in_sel,
    input  logic signed [DW-1:0] in_re,
    input  logic signed [DW-1:0] in_im,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_re,
    output logic signed [DW-1:0] out_im
);

    tw_ctl_t              ctl_q;
    logic signed [OW-1:0] op_re_q, op_im_q;
    logic signed [OW-1:0] sc_re, sc_im;
    logic signed [OW-1:0] pick_re, pick_im;
    logic signed [DW-1:0] clip_re, clip_im;

    twm_prep #(.DW(DW)) u_prep (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sel   (in_sel),
        .in_re    (in_re),
        .in_im    (in_im),
        .ctl_q    (ctl_q),
        .op_re_q  (op_re_q),
        .op_im_q  (op_im_q)
    );

    twm_csd_scale #(.IW(OW), .FRAC(CSD_FRAC), .NT(CSD_TERMS),
                    .SHIFTS(CSD_SHIFTS), .NEGS(CSD_NEGS)) u_scale_re (
        .x (op_re_q),
        .y (sc_re)
    );

    twm_csd_scale #(.IW(OW), .FRAC(CSD_FRAC), .NT(CSD_TERMS),
                    .SHIFTS(CSD_SHIFTS), .NEGS(CSD_NEGS)) u_scale_im (
        .x (op_im_q),
        .y (sc_im)
    );

    assign pick_re = ctl_q.scale ? sc_re : op_re_q;
    assign pick_im = ctl_q.scale ? sc_im : op_im_q;

    twm_sat #(.IW(OW), .OW(DW)) u_sat_re (.d(pick_re), .q(clip_re));
    twm_sat #(.IW(OW), .OW(DW)) u_sat_im (.d(pick_im), .q(clip_im));

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_re    <= '0;
            out_im    <= '0;
        end else begin
            out_valid <= ctl_q.vld;
            if (ctl_q.vld) begin
                out_re <= clip_re;
                out_im <= clip_im;
            end
        end
    end

    // Cycles since reset, used to keep the latency check inside known history
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= '0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end

    // R2: fixed two-clock latency of the qualifier
    p_latency_two_r2: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R8: no accepted sample, no change on the data outputs
    p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ctl_q.vld)) |-> ($stable(out_re) && $stable(out_im)));

    // R5: the scaled path keeps the sign of its operand
    p_sign_kept_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ctl_q.vld) && $past(ctl_q.scale))
        |-> (out_re == '0 || out_re[DW-1] == $past(op_re_q[OW-1])));

endmodule

// File: tb/twiddle_csd_mul_test.sv
`timescale 1ns/1ps
module twiddle_csd_mul_test;

    localparam int DW   = 13;
    localparam int MAXV = 4095;
    localparam int MINV = -4096;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 in_valid;
    logic [1:0]           in_sel;
    logic signed [DW-1:0] in_re, in_im;
    logic                 out_valid;
    logic signed [DW-1:0] out_re, out_im;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    // Expected result for the beat currently visible at the outputs
    logic   cur_v;
    integer cur_re, cur_im;
    string  cur_tag;
    integer last_re, last_im;

    always #2 clk = ~clk;

    twiddle_csd_mul #(.DW(DW)) uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sel    (in_sel),
        .in_re     (in_re),
        .in_im     (in_im),
        .out_valid (out_valid),
        .out_re    (out_re),
        .out_im    (out_im)
    );

    function automatic integer clip(input integer x);
        if (x > MAXV) return MAXV;
        if (x < MINV) return MINV;
        return x;
    endfunction

    function automatic integer scl(input integer x);
        integer p;
        p = x * 181 + 128;
        return clip(p >>> 8);
    endfunction

    task automatic check(input string tag, input logic ev, input integer er, input integer ei);
        checks++;
        if (out_valid !== ev || integer'(out_re) != er || integer'(out_im) != ei) begin
            errors++;
            $display("FAIL %s: got v=%0b re=%0d im=%0d expected v=%0b re=%0d im=%0d",
                     tag, out_valid, out_re, out_im, ev, er, ei);
        end
    endtask

    // Drive one beat, then check the beat issued one step earlier
    task automatic step(input logic v, input logic [1:0] s, input integer a,
                        input integer b, input string tag);
        integer er, ei;
        er = last_re;
        ei = last_im;
        if (v) begin
            case (s)
                2'b00: begin er = a;             ei = b;             end
                2'b01: begin er = b;             ei = clip(-a);      end
                2'b10: begin er = scl(a + b);    ei = scl(b - a);    end
                default: begin er = scl(b - a);  ei = scl(-(a + b)); end
            endcase
            last_re = er;
            last_im = ei;
        end
        in_valid = v;
        in_sel   = s;
        in_re    = DW'(a);
        in_im    = DW'(b);
        @(negedge clk);
        check(cur_tag, cur_v, cur_re, cur_im);
        cur_v   = v;
        cur_re  = er;
        cur_im  = ei;
        cur_tag = tag;
    endtask

    task automatic flush(input string tag);
        step(1'b0, 2'b00, 0, 0, tag);
        step(1'b0, 2'b00, 0, 0, tag);
    endtask

    task automatic t_reset;
        rst      = 1'b1;
        in_valid = 1'b1;
        in_sel   = 2'b10;
        in_re    = 13'sd1000;
        in_im    = -13'sd700;
        repeat (3) @(negedge clk);
        // R1: reset dominates live input
        check("R1", 1'b0, 0, 0);
        rst      = 1'b0;
        in_valid = 1'b0;
        last_re  = 0;
        last_im  = 0;
        cur_v    = 1'b0;
        cur_re   = 0;
        cur_im   = 0;
        cur_tag  = "R1";
    endtask

    task automatic t_unity;
        step(1'b1, 2'b00, 123, -456, "R3");
        step(1'b1, 2'b00, MINV, MAXV, "R3");
        step(1'b1, 2'b00, 0, -1, "R3");
        flush("R2");
    endtask

    task automatic t_negj;
        step(1'b1, 2'b01, 300, 77, "R4");
        step(1'b1, 2'b01, -2500, -9, "R4");
        step(1'b1, 2'b01, MINV, 5, "R4");  // negation clips to +4095
        flush("R4");
    endtask

    task automatic t_m45;
        step(1'b1, 2'b10, 1000, 0, "R5");
        step(1'b1, 2'b10, 100, 200, "R5");
        step(1'b1, 2'b10, -1, 0, "R5");
        step(1'b1, 2'b10, -1234, 567, "R5");
        flush("R5");
    endtask

    task automatic t_m135;
        step(1'b1, 2'b11, 1000, 0, "R6");
        step(1'b1, 2'b11, -300, 800, "R6");
        step(1'b1, 2'b11, 1, 1, "R6");
        flush("R6");
    endtask

    task automatic t_saturate;
        step(1'b1, 2'b10, MAXV, MAXV, "R7");
        step(1'b1, 2'b10, MINV, MINV, "R7");
        step(1'b1, 2'b11, MINV, MINV, "R7");
        step(1'b1, 2'b11, MAXV, MINV, "R7");
        flush("R7");
    endtask

    task automatic t_hold;
        step(1'b1, 2'b10, 2000, -600, "R8");
        // Idle beats carry data that would change the result if accepted
        step(1'b0, 2'b01, 1500, 1500, "R8");
        step(1'b0, 2'b11, -900, 42, "R8");
        step(1'b0, 2'b00, 7, 7, "R8");
        flush("R8");
    endtask

    task automatic t_stream;
        step(1'b1, 2'b00, 11, 22, "R9");
        step(1'b1, 2'b01, 11, 22, "R9");
        step(1'b1, 2'b10, 11, 22, "R9");
        step(1'b1, 2'b11, 11, 22, "R9");
        step(1'b0, 2'b00, 0, 0, "R2");
        step(1'b1, 2'b11, -3000, 2999, "R9");
        step(1'b1, 2'b00, -3000, 2999, "R9");
        flush("R2");
    endtask

    initial begin
        in_valid = 1'b0;
        in_sel   = 2'b00;
        in_re    = '0;
        in_im    = '0;
        rst      = 1'b1;
        @(negedge clk);
        t_reset();
        t_unity();
        t_negj();
        t_m45();
        t_m135();
        t_saturate();
        t_hold();
        t_stream();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule